// File: doc/BRIEF.md
# Halt Source Evaluator and Arbiter

This block collects every event that can stop the core for debug and turns them into a single halt request with a 6-bit reason code. The halt state machine downstream consumes that request.

The most involved source is the exception-catch check. When an exception is taken or returned from, the block picks control bits from a 16-bit catch word. The choice depends on the privilege level the core lands in and on its security state. In the extended mode a two-bit control pair lets the catch fire on entry only, on exit only, on both, or never.

Reset catch and OS-unlock catch are held as pending bits. The external debug request is a level input that is honoured only while halting is allowed. An accepted exception-catch event is also held until it is taken. All sources are gated by the halting-allowed flag. They are ranked by a fixed priority, and a pending source is cleared only when the consumer acknowledges a halt carrying that source's reason.

Top module: `catch_halt_arbiter`

## Requirements
- R1: The catch bit index is `cur_el` when `in_secure` is 1, or `cur_el + 4` when `in_secure` is 0. The low control bit is `catch_ctrl[index]`.
- R2: With `ext_catch_mode` = 1, the control pair is {`catch_ctrl[index+8]`, `catch_ctrl[index]`}. 2'b00 never catches, 2'b01 catches entry and exit, 2'b10 catches only exit (`exc_is_entry` = 0), and 2'b11 catches only entry (`exc_is_entry` = 1).
- R3: With `ext_catch_mode` = 0, an event is caught exactly when `catch_ctrl[index]` is 1, for both entry and exit.
- R4: While `halt_allowed` is 0, `halt_req` is 0 in the same cycle. An exception event that arrives while `halt_allowed` is 0 is dropped and never raises a request later.
- R5: A `reset_exit` pulse with `rst_catch_en` = 1 sets the reset-catch pending bit. From the next cycle, `halt_req` = 1 with `halt_reason` = 6'b100111 whenever halting is allowed. With `rst_catch_en` = 0 the pulse has no effect.
- R6: An `os_lock_release` pulse with `osu_catch_en` = 1 and `core_halted` = 0 sets the OS-unlock pending bit, which gives reason 6'b100011. The pulse is ignored when `core_halted` = 1 or `osu_catch_en` = 0.
- R7: `ext_dbg_req` = 1 with `halt_allowed` = 1 gives `halt_req` = 1 with reason 6'b010011 in the same cycle. The request is not stored, so it ends when the input falls.
- R8: When several sources are valid, the reason shown is the first one present in this order: reset catch, OS-unlock catch, exception catch, external request.
- R9: A pending source stays set, including across cycles with `halt_allowed` = 0, until `halt_ack` is 1 in a cycle where that source's reason is shown. The acknowledge clears only that source, at that clock edge.
- R10: A caught exception event sets a pending bit that gives reason 6'b110111 from the next cycle until it is acknowledged.
- R11: During and right after reset, `halt_req` is 0 and all pending bits are clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| exc_evt | input | 1 | One-cycle strobe: an exception entry or exit has completed |
| exc_is_entry | input | 1 | 1 for exception entry, 0 for exception return |
| cur_el | input | 2 | Privilege level after the event |
| in_secure | input | 1 | 1 when the core is in secure state |
| catch_ctrl | input | 16 | Catch control word |
| ext_catch_mode | input | 1 | Selects the two-bit control pair |
| halt_allowed | input | 1 | Halting currently permitted |
| rst_catch_en | input | 1 | Reset catch enabled |
| reset_exit | input | 1 | Strobe: the core has left reset |
| osu_catch_en | input | 1 | OS-unlock catch enabled |
| os_lock_release | input | 1 | Strobe: the OS lock was cleared |
| core_halted | input | 1 | Core is already in debug state |
| ext_dbg_req | input | 1 | External debug request level |
| halt_ack | input | 1 | Consumer takes the halt currently shown |
| halt_req | output | 1 | Halt request |
| halt_reason | output | 6 | Reason code of the winning source |

## Verification
A pending bit stuck at 1 shows as a request that returns right after an acknowledge. A pending bit that never sets shows as a missing request one cycle after the strobe. Both are seen at the next sample after the edge concerned.

A wrong index or decode of the control pair shows up one cycle after the event strobe. It appears either as a spurious reason 110111 or as a missing one. A wrong priority ranking appears as the wrong reason in the same cycle that several sources are valid.

// File: rtl/catch_pkg.sv
package catch_pkg;
  localparam int REASON_W = 6;
  typedef logic [REASON_W-1:0] reason_t;

  // Reason codes read by the halt state machine
  localparam reason_t RSN_RESET_CATCH = 6'b100111;
  localparam reason_t RSN_OS_UNLOCK   = 6'b100011;
  localparam reason_t RSN_EXC_CATCH   = 6'b110111;
  localparam reason_t RSN_EXT_REQ     = 6'b010011;

  // Source slots, lowest index has highest priority
  localparam int SRC_N   = 4;
  localparam int SRC_RST = 0;
  localparam int SRC_OSU = 1;
  localparam int SRC_EXC = 2;
  localparam int SRC_EXT = 3;
  localparam int PEND_N  = 3;  // slots 0..2 are stored, slot 3 is a level
endpackage

// File: rtl/exc_catch_decode.sv
module exc_catch_decode #(
  parameter int NUM_EL = 4
) (
  input  logic [$clog2(NUM_EL)-1:0] el,
  input  logic                      secure,
  input  logic                      is_entry,
  input  logic                      ext_mode,
  input  logic [4*NUM_EL-1:0]       ctrl,
  output logic                      hit
);
  localparam int ELW    = $clog2(NUM_EL);
  localparam int CTRL_W = 4 * NUM_EL;
  localparam int CIW    = $clog2(CTRL_W);

  logic [CIW-1:0] lo_idx;
  logic [CIW-1:0] hi_idx;
  logic           lo_bit;
  logic           hi_bit;

  always_comb begin
    lo_idx = CIW'(el) + (secure ? CIW'(0) : CIW'(NUM_EL));
    hi_idx = lo_idx + CIW'(2 * NUM_EL);
    lo_bit = ctrl[lo_idx];
    hi_bit = ctrl[hi_idx];
  end

  always_comb begin
    if (ext_mode) begin
      unique case ({hi_bit, lo_bit})
        2'b00:   hit = 1'b0;
        2'b01:   hit = 1'b1;
        2'b10:   hit = ~is_entry;
        default: hit = is_entry;
      endcase
    end else begin
      hit = lo_bit;
    end
  end

  logic unused_w;
  assign unused_w = ^{ELW{1'b0}};
endmodule

// File: rtl/sticky_pend.sv
module sticky_pend (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q
);
  logic q_nxt;

  // A new event in the acknowledge cycle wins over the clear
  always_comb begin
    q_nxt = q;
    if (clr_i) q_nxt = 1'b0;
    if (set_i) q_nxt = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= 1'b0;
    else        q <= q_nxt;
  end
endmodule

// File: rtl/halt_prio_pick.sv
module halt_prio_pick #(
  parameter int N  = 4,
  parameter int CW = 6
) (
  input  logic [N-1:0]         valid,
  input  logic [N-1:0][CW-1:0] codes,
  output logic                 any,
  output logic [N-1:0]         grant,
  output logic [CW-1:0]        code
);
  always_comb begin
    grant = '0;
    code  = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (valid[i]) begin
        grant    = '0;
        grant[i] = 1'b1;
        code     = codes[i];
      end
    end
    any = |valid;
  end
endmodule

// File: rtl/catch_halt_arbiter.sv
module catch_halt_arbiter
  import catch_pkg::*;
#(
  parameter int NUM_EL = 4,
  localparam int ELW    = $clog2(NUM_EL),
  localparam int CTRL_W = 4 * NUM_EL
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              exc_evt,
  input  logic              exc_is_entry,
  input  logic [ELW-1:0]    cur_el,
  input  logic              in_secure,
  input  logic [CTRL_W-1:0] catch_ctrl,
  input  logic              ext_catch_mode,
  input  logic              halt_allowed,
  input  logic              rst_catch_en,
  input  logic              reset_exit,
  input  logic              osu_catch_en,
  input  logic              os_lock_release,
  input  logic              core_halted,
  input  logic              ext_dbg_req,
  input  logic              halt_ack,
  output logic              halt_req,
  output logic [REASON_W-1:0] halt_reason
);
  logic                          exc_hit;
  logic [PEND_N-1:0]             pend_set;
  logic [PEND_N-1:0]             pend_clr;
  logic [PEND_N-1:0]             pend_q;
  logic [SRC_N-1:0]              src_valid;
  logic [SRC_N-1:0]              src_grant;
  logic [SRC_N-1:0][REASON_W-1:0] src_code;

  exc_catch_decode #(.NUM_EL(NUM_EL)) u_dec (
    .el       (cur_el),
    .secure   (in_secure),
    .is_entry (exc_is_entry),
    .ext_mode (ext_catch_mode),
    .ctrl     (catch_ctrl),
    .hit      (exc_hit)
  );

  always_comb begin
    pend_set          = '0;
    pend_set[SRC_RST] = reset_exit & rst_catch_en;
    pend_set[SRC_OSU] = os_lock_release & osu_catch_en & ~core_halted;
    pend_set[SRC_EXC] = exc_evt & exc_hit & halt_allowed;
    pend_clr          = {PEND_N{halt_ack}} & src_grant[PEND_N-1:0];
  end

  for (genvar g = 0; g < PEND_N; g++) begin : g_pend
    sticky_pend u_pend (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (pend_set[g]),
      .clr_i (pend_clr[g]),
      .q     (pend_q[g])
    );
  end

  always_comb begin
    src_code          = '0;
    src_code[SRC_RST] = RSN_RESET_CATCH;
    src_code[SRC_OSU] = RSN_OS_UNLOCK;
    src_code[SRC_EXC] = RSN_EXC_CATCH;
    src_code[SRC_EXT] = RSN_EXT_REQ;
    src_valid         = {ext_dbg_req, pend_q} & {SRC_N{halt_allowed}};
  end

  halt_prio_pick #(.N(SRC_N), .CW(REASON_W)) u_pick (
    .valid (src_valid),
    .codes (src_code),
    .any   (halt_req),
    .grant (src_grant),
    .code  (halt_reason)
  );
endmodule

// File: rtl/catch_halt_arbiter_chk.sv
module catch_halt_arbiter_chk
  import catch_pkg::*;
(
  input logic                clk,
  input logic                rst_n,
  input logic                halt_allowed,
  input logic                rst_catch_en,
  input logic                reset_exit,
  input logic                ext_dbg_req,
  input logic                halt_ack,
  input logic                halt_req,
  input logic [REASON_W-1:0] halt_reason
);
  logic past_ok;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  a_r4_gated: assert property (@(posedge clk) disable iff (!rst_n)
    !halt_allowed |-> !halt_req);

  a_r7_ext_taken: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_dbg_req && halt_allowed) |-> halt_req);

  a_r5_reset_first: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(reset_exit && rst_catch_en) && halt_allowed)
      |-> (halt_req && halt_reason == RSN_RESET_CATCH));

  a_r9_hold_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(halt_req && halt_reason == RSN_RESET_CATCH && !halt_ack) && halt_allowed)
      |-> (halt_req && halt_reason == RSN_RESET_CATCH));

  a_r8_legal_code: assert property (@(posedge clk) disable iff (!rst_n)
    halt_req |-> (halt_reason == RSN_RESET_CATCH || halt_reason == RSN_OS_UNLOCK ||
                  halt_reason == RSN_EXC_CATCH   || halt_reason == RSN_EXT_REQ));
endmodule

bind catch_halt_arbiter catch_halt_arbiter_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .halt_allowed (halt_allowed),
  .rst_catch_en (rst_catch_en),
  .reset_exit   (reset_exit),
  .ext_dbg_req  (ext_dbg_req),
  .halt_ack     (halt_ack),
  .halt_req     (halt_req),
  .halt_reason  (halt_reason)
);

// File: tb/tb_catch_halt_arbiter.sv
module tb_catch_halt_arbiter;
  localparam logic [5:0] C_RC  = 6'b100111;
  localparam logic [5:0] C_OSU = 6'b100011;
  localparam logic [5:0] C_EXC = 6'b110111;
  localparam logic [5:0] C_EXT = 6'b010011;

  logic clk = 1'b0;
  logic rst_n;
  logic exc_evt, exc_is_entry, in_secure, ext_catch_mode, halt_allowed;
  logic [1:0] cur_el;
  logic [15:0] catch_ctrl;
  logic rst_catch_en, reset_exit, osu_catch_en, os_lock_release, core_halted;
  logic ext_dbg_req, halt_ack, halt_req;
  logic [5:0] halt_reason;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  catch_halt_arbiter dut (
    .clk(clk), .rst_n(rst_n), .exc_evt(exc_evt), .exc_is_entry(exc_is_entry),
    .cur_el(cur_el), .in_secure(in_secure), .catch_ctrl(catch_ctrl),
    .ext_catch_mode(ext_catch_mode), .halt_allowed(halt_allowed),
    .rst_catch_en(rst_catch_en), .reset_exit(reset_exit), .osu_catch_en(osu_catch_en),
    .os_lock_release(os_lock_release), .core_halted(core_halted),
    .ext_dbg_req(ext_dbg_req), .halt_ack(halt_ack), .halt_req(halt_req),
    .halt_reason(halt_reason)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic ack_one();
    halt_ack = 1'b1;
    tick();
    halt_ack = 1'b0;
  endtask

  // One exception event; expectation derived from the requirement tables
  task automatic t_exc(input string rq, input logic [1:0] el, input logic sec,
                       input logic entry, input logic [15:0] ctrl, input logic ext,
                       input logic exp);
    cur_el = el; in_secure = sec; exc_is_entry = entry;
    catch_ctrl = ctrl; ext_catch_mode = ext;
    exc_evt = 1'b1;
    tick();
    exc_evt = 1'b0;
    chk(rq, {31'd0, halt_req}, {31'd0, exp});
    if (exp) chk({rq, " reason (R10)"}, {26'd0, halt_reason}, {26'd0, C_EXC});
    if (halt_req) begin
      ack_one();
      chk({rq, " cleared by ack (R9)"}, {31'd0, halt_req}, 32'd0);
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    exc_evt = 0; exc_is_entry = 0; cur_el = 0; in_secure = 1; catch_ctrl = 0;
    ext_catch_mode = 0; halt_allowed = 0; rst_catch_en = 0; reset_exit = 0;
    osu_catch_en = 0; os_lock_release = 0; core_halted = 0; ext_dbg_req = 0; halt_ack = 0;
    tick(); tick();
    chk("R11 in reset", {31'd0, halt_req}, 32'd0);
    rst_n = 1'b1;
    halt_allowed = 1'b1;
    tick();
    chk("R11 after reset", {31'd0, halt_req}, 32'd0);
  endtask

  task automatic t_index_plain();
    t_exc("R1 R3 EL1 secure bit1", 2'd1, 1'b1, 1'b1, 16'h0002, 1'b0, 1'b1);
    t_exc("R1 EL1 nonsecure uses bit5", 2'd1, 1'b0, 1'b1, 16'h0002, 1'b0, 1'b0);
    t_exc("R1 R3 EL2 nonsecure bit6 exit", 2'd2, 1'b0, 1'b0, 16'h0040, 1'b0, 1'b1);
    t_exc("R3 high bit ignored in plain mode", 2'd3, 1'b1, 1'b1, 16'h0800, 1'b0, 1'b0);
  endtask

  task automatic t_ext_pairs();
    t_exc("R2 00 entry never", 2'd3, 1'b1, 1'b1, 16'h0000, 1'b1, 1'b0);
    t_exc("R2 01 entry", 2'd3, 1'b1, 1'b1, 16'h0008, 1'b1, 1'b1);
    t_exc("R2 01 exit", 2'd3, 1'b1, 1'b0, 16'h0008, 1'b1, 1'b1);
    t_exc("R2 10 entry blocked", 2'd3, 1'b1, 1'b1, 16'h0800, 1'b1, 1'b0);
    t_exc("R2 10 exit", 2'd3, 1'b1, 1'b0, 16'h0800, 1'b1, 1'b1);
    t_exc("R2 11 entry", 2'd3, 1'b1, 1'b1, 16'h0808, 1'b1, 1'b1);
    t_exc("R2 11 exit blocked", 2'd3, 1'b1, 1'b0, 16'h0808, 1'b1, 1'b0);
    t_exc("R1 R2 EL0 nonsecure pair 12/4 exit", 2'd0, 1'b0, 1'b0, 16'h1000, 1'b1, 1'b1);
  endtask

  task automatic t_not_allowed();
    halt_allowed = 1'b0;
    t_exc("R4 exception while not allowed", 2'd1, 1'b1, 1'b1, 16'h0002, 1'b0, 1'b0);
    halt_allowed = 1'b1;
    #1;
    chk("R4 dropped event stays dropped", {31'd0, halt_req}, 32'd0);
    ext_dbg_req = 1'b1; halt_allowed = 1'b0;
    #1;
    chk("R7 R4 external blocked", {31'd0, halt_req}, 32'd0);
    halt_allowed = 1'b1;
    #1;
    chk("R7 external taken", {26'd0, halt_reason}, {26'd0, C_EXT});
    ext_dbg_req = 1'b0;
    #1;
    chk("R7 external not stored", {31'd0, halt_req}, 32'd0);
  endtask

  task automatic t_priority();
    rst_catch_en = 1; reset_exit = 1; osu_catch_en = 1; os_lock_release = 1;
    ext_dbg_req = 1;
    tick();
    reset_exit = 0; os_lock_release = 0;
    chk("R5 R8 reset catch wins", {26'd0, halt_reason}, {26'd0, C_RC});
    tick();
    chk("R9 held without ack", {26'd0, halt_reason}, {26'd0, C_RC});
    halt_allowed = 0;
    tick();
    chk("R4 pending masked", {31'd0, halt_req}, 32'd0);
    halt_allowed = 1;
    #1;
    chk("R9 pending kept while masked", {26'd0, halt_reason}, {26'd0, C_RC});
    ack_one();
    chk("R6 R8 OS unlock next", {26'd0, halt_reason}, {26'd0, C_OSU});
    ack_one();
    chk("R8 external last", {26'd0, halt_reason}, {26'd0, C_EXT});
    cur_el = 2'd1; in_secure = 1; ext_catch_mode = 0; catch_ctrl = 16'h0002;
    exc_is_entry = 1; exc_evt = 1;
    tick();
    exc_evt = 0;
    chk("R8 R10 exception over external", {26'd0, halt_reason}, {26'd0, C_EXC});
    ack_one();
    chk("R9 ack clears only exception", {26'd0, halt_reason}, {26'd0, C_EXT});
    ext_dbg_req = 0;
    #1;
    chk("R9 all clear", {31'd0, halt_req}, 32'd0);
  endtask

  task automatic t_ignored();
    core_halted = 1; osu_catch_en = 1; os_lock_release = 1;
    tick();
    os_lock_release = 0; core_halted = 0;
    tick();
    chk("R6 unlock ignored while halted", {31'd0, halt_req}, 32'd0);
    osu_catch_en = 0; os_lock_release = 1;
    tick();
    os_lock_release = 0;
    chk("R6 unlock ignored when disabled", {31'd0, halt_req}, 32'd0);
    rst_catch_en = 0; reset_exit = 1;
    tick();
    reset_exit = 0;
    chk("R5 reset exit ignored when disabled", {31'd0, halt_req}, 32'd0);
    halt_allowed = 0; rst_catch_en = 1; reset_exit = 1;
    tick();
    reset_exit = 0;
    chk("R5 R4 reset catch waits", {31'd0, halt_req}, 32'd0);
    halt_allowed = 1;
    #1;
    chk("R5 reset catch once allowed", {26'd0, halt_reason}, {26'd0, C_RC});
    ack_one();
    chk("R9 reset catch cleared", {31'd0, halt_req}, 32'd0);
  endtask

  initial begin
    t_reset();
    t_index_plain();
    t_ext_pairs();
    t_not_allowed();
    t_priority();
    t_ignored();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule